// File: doc/BRIEF.md
# Oversampled Coded Packet Stimulus Generator

This block drives one channel of serial test stimulus onto a line that is sampled by a common fast clock. On a start request it sends a message of N packets back to back. Each packet is an unencoded start tag, a payload encoded as Manchester or Miller, and an unencoded stop tag. Every tag bit and every encoded half-bit is held for a programmable number of sample clocks. Channels that run at different data rates can therefore share one sample clock.

The payload comes either from a fixed user pattern or from a seeded PRBS-9 generator. Seeding several channels differently makes their streams mutually non-coherent. The two halves of each payload bit can be skewed against each other in whole sample steps. The skew is a static duty-cycle bias plus, optionally, a random per-bit jitter. The bit period never changes. A one-cycle trigger marks the first sample of a message, so capture equipment can start from it. Per-packet and end-of-message strobes mark the progress of the message.

The controller is a four-state machine:
- `ST_IDLE` holds the line low.
- `ST_SOT` sends the start tag.
- `ST_PAY` sends the payload, with a half flag that selects the first or second half of the current bit.
- `ST_EOT` sends the stop tag.

The transitions are:
- IDLE→SOT on an accepted start.
- SOT→PAY after the last start-tag bit.
- PAY→EOT after the second half of the last payload bit.
- EOT→SOT after the last stop-tag bit while packets remain.
- EOT→IDLE after the last stop-tag bit of the last packet.

Top module: `pkt_stim_gen`

## Requirements
- R1: A start request is accepted only in idle with a nonzero packet count. On acceptance, `trig_o` is high for exactly the first sample cycle of the message and `busy_o` is high from that cycle on. A start request while busy, or with a packet count of zero, changes nothing.
- R2: Each packet is sent in this order: the start tag, then PAY_BITS encoded payload bits, then the stop tag. Tags are sent most significant bit first, as plain levels, each bit lasting 2·H samples, where H = `half_len_i` ≥ 1. `pkt_count_i` packets follow each other with no gap.
- R3: In Manchester mode (`miller_i`=0), a payload 1 is sent as high then low, and a 0 as low then high.
- R4: In Miller mode (`miller_i`=1), let L be the level after the previous bit. A 1 is sent as L then ¬L. A 0 after a 0 is sent as ¬L for both halves. A 0 after a 1 is sent as L for both halves. At each packet start, L is bit 0 of the start tag and the previous bit counts as 1.
- R5: With `prbs_i`=0, the payload is `pattern_i`, most significant bit first, in every packet. With `prbs_i`=1, a 9-bit state is loaded from `seed_i` at start, with a zero seed replaced by 1. Each payload bit is state[8], and the state then becomes {state[7:0], state[8]^state[4]}. The state carries over across the packets of a message.
- R6: The first half of a payload bit lasts H+d samples and the second lasts H−d samples. d is the signed value `bias_i` (plus jitter), clamped to the range −(H−1)..H−1.
- R7: With `jitter_en_i`=1, a pseudo-random value in −8..7 is added to the bias of each payload bit before clamping. Tags are never distorted, and the message length does not change.
- R8: `pkt_done_o` pulses for one cycle in the first sample after each packet. On the last packet, `msg_done_o` pulses in that same cycle, `busy_o` is low, and the line is low.
- R9: After reset and whenever the block is idle, `line_o`, `trig_o`, `busy_o` and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request |
| miller_i | input | 1 | 1 = Miller coding, 0 = Manchester |
| prbs_i | input | 1 | 1 = PRBS-9 payload, 0 = fixed pattern |
| seed_i | input | 9 | PRBS seed |
| pattern_i | input | PAY_BITS | Fixed payload pattern |
| sot_tag_i | input | TAG_BITS | Start tag |
| eot_tag_i | input | TAG_BITS | Stop tag |
| pkt_count_i | input | NPW | Packets per message |
| half_len_i | input | HW | Samples per half-bit (H) |
| bias_i | input | HW | Signed duty-cycle bias in samples |
| jitter_en_i | input | 1 | Enable random per-bit skew |
| line_o | output | 1 | Serial stimulus line |
| trig_o | output | 1 | Acquisition trigger pulse |
| busy_o | output | 1 | Message in progress |
| pkt_done_o | output | 1 | End-of-packet strobe |
| msg_done_o | output | 1 | End-of-message strobe |

## Verification
The embedded properties check the following on every cycle:
- the line is low when idle;
- the trigger only appears while busy, and never after a start request made while busy;
- the end-of-message strobe coincides with an end-of-packet strobe and with the return to idle;
- the applied skew stays inside ±(H−1), so no half-bit collapses.

Only the bench's sweeps can show the exact sample-by-sample waveform. That covers the tag order, both encodings including the Miller boundary rule, PRBS continuity across packets, bias clamping, and the positions of the strobes. For jitter, the bench can show that the tags and the total length stay exact while the payload edges move.

// File: rtl/stim_pkg.sv
package stim_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SOT,
        ST_PAY,
        ST_EOT
    } stim_state_t;
endpackage

// File: rtl/prbs9_src.sv
module prbs9_src #(
    parameter int OUT_LSB = 8,
    parameter int OUT_W   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [8:0]       seed,
    input  logic             step,
    output logic [OUT_W-1:0] tap_o
);
    logic [8:0] st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= 9'h001;
        else if (load)
            st_q <= (seed == 9'h000) ? 9'h001 : seed;
        else if (step)
            st_q <= {st_q[7:0], st_q[8] ^ st_q[4]};
    end

    assign tap_o = st_q[OUT_LSB +: OUT_W];

    // R5
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != 9'h000);
endmodule

// File: rtl/line_coder.sv
module line_coder (
    input  logic bit_i,
    input  logic miller,
    input  logic lvl_i,
    input  logic prev_i,
    output logic h0_o,
    output logic h1_o
);
    always_comb begin
        if (!miller) begin
            h0_o = bit_i;
            h1_o = ~bit_i;
        end else if (bit_i) begin
            h0_o = lvl_i;
            h1_o = ~lvl_i;
        end else if (!prev_i) begin
            h0_o = ~lvl_i;
            h1_o = ~lvl_i;
        end else begin
            h0_o = lvl_i;
            h1_o = lvl_i;
        end
    end
endmodule

// File: rtl/edge_offset.sv
module edge_offset #(
    parameter int HW = 8
) (
    input  logic [HW-1:0]        half_len,
    input  logic [HW-1:0]        bias,
    input  logic [3:0]           jit,
    input  logic                 jit_en,
    output logic signed [HW+1:0] off_o
);
    logic signed [HW+1:0] hl_s, lim, sum;

    always_comb begin
        hl_s = $signed({2'b00, half_len});
        lim  = (half_len == '0) ? '0 : hl_s - 1;
        sum  = $signed({{2{bias[HW-1]}}, bias});
        if (jit_en)
            sum = sum + $signed({{(HW-2){jit[3]}}, jit});
        if (sum > lim)
            off_o = lim;
        else if (sum < -lim)
            off_o = -lim;
        else
            off_o = sum;
    end
endmodule

// File: rtl/pkt_stim_gen.sv
module pkt_stim_gen
    import stim_pkg::*;
#(
    parameter int TAG_BITS = 8,
    parameter int PAY_BITS = 8,
    parameter int HW       = 8,
    parameter int NPW      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                miller_i,
    input  logic                prbs_i,
    input  logic [8:0]          seed_i,
    input  logic [PAY_BITS-1:0] pattern_i,
    input  logic [TAG_BITS-1:0] sot_tag_i,
    input  logic [TAG_BITS-1:0] eot_tag_i,
    input  logic [NPW-1:0]      pkt_count_i,
    input  logic [HW-1:0]       half_len_i,
    input  logic [HW-1:0]       bias_i,
    input  logic                jitter_en_i,
    output logic                line_o,
    output logic                trig_o,
    output logic                busy_o,
    output logic                pkt_done_o,
    output logic                msg_done_o
);
    localparam int TW = (TAG_BITS > 1) ? $clog2(TAG_BITS) : 1;
    localparam int PW = (PAY_BITS > 1) ? $clog2(PAY_BITS) : 1;
    localparam int CW = HW + 1;

    stim_state_t st, st_nx;

    logic [TW-1:0]        tidx;
    logic [PW-1:0]        pidx, fetch_idx;
    logic [CW-1:0]        cnt, full_len, first_len, second_len;
    logic [NPW-1:0]       left;
    logic                 half_q, h1_q, mil_lvl, mil_prev;
    logic                 line_q, trig_q, pkt_q, msg_q;
    logic signed [HW+1:0] off, off_q, hl_s, len_a, len_b;
    logic                 accept, seg_end, tag_last, pay_last, fetch;
    logic                 data_bit, h0, h1, lvl_in, prev_in;
    logic [0:0]           dat_tap;
    logic [3:0]           jit_tap;
    logic [TAG_BITS-1:0]  sot_rev, eot_rev;
    logic [PAY_BITS-1:0]  pat_rev;

    // Bit-reverse tags and pattern so transmit order is ascending index.
    for (genvar g = 0; g < TAG_BITS; g++) begin : g_tag_rev
        assign sot_rev[g] = sot_tag_i[TAG_BITS-1-g];
        assign eot_rev[g] = eot_tag_i[TAG_BITS-1-g];
    end
    for (genvar g = 0; g < PAY_BITS; g++) begin : g_pat_rev
        assign pat_rev[g] = pattern_i[PAY_BITS-1-g];
    end

    assign accept   = (st == ST_IDLE) && start_i && (pkt_count_i != '0);
    assign seg_end  = (st != ST_IDLE) && (cnt == '0);
    assign tag_last = (tidx == TW'(TAG_BITS-1));
    assign pay_last = (pidx == PW'(PAY_BITS-1));
    assign fetch    = seg_end && (((st == ST_SOT) && tag_last) ||
                                  ((st == ST_PAY) && half_q && !pay_last));
    assign fetch_idx = (st == ST_SOT) ? '0 : pidx + 1'b1;
    assign data_bit  = prbs_i ? dat_tap[0] : pat_rev[fetch_idx];
    assign lvl_in    = (st == ST_SOT) ? sot_tag_i[0] : mil_lvl;
    assign prev_in   = (st == ST_SOT) ? 1'b1 : mil_prev;

    assign hl_s       = $signed({2'b00, half_len_i});
    assign len_a      = hl_s + off - 1;
    assign len_b      = hl_s - off_q - 1;
    assign first_len  = len_a[CW-1:0];
    assign second_len = len_b[CW-1:0];
    assign full_len   = {half_len_i, 1'b0} - 1'b1;

    prbs9_src #(.OUT_LSB(8), .OUT_W(1)) u_data (
        .clk(clk), .rst_n(rst_n), .load(accept), .seed(seed_i),
        .step(fetch && prbs_i), .tap_o(dat_tap)
    );

    prbs9_src #(.OUT_LSB(0), .OUT_W(4)) u_jit (
        .clk(clk), .rst_n(rst_n), .load(accept), .seed(~seed_i),
        .step(fetch), .tap_o(jit_tap)
    );

    line_coder u_coder (
        .bit_i(data_bit), .miller(miller_i), .lvl_i(lvl_in),
        .prev_i(prev_in), .h0_o(h0), .h1_o(h1)
    );

    edge_offset #(.HW(HW)) u_off (
        .half_len(half_len_i), .bias(bias_i), .jit(jit_tap),
        .jit_en(jitter_en_i), .off_o(off)
    );

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (accept) st_nx = ST_SOT;
            ST_SOT:  if (seg_end && tag_last) st_nx = ST_PAY;
            ST_PAY:  if (seg_end && half_q && pay_last) st_nx = ST_EOT;
            ST_EOT:  if (seg_end && tag_last)
                         st_nx = (left == NPW'(1)) ? ST_IDLE : ST_SOT;
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tidx <= '0; pidx <= '0; cnt <= '0; left <= '0;
            half_q <= 1'b0; h1_q <= 1'b0; off_q <= '0;
            mil_lvl <= 1'b0; mil_prev <= 1'b1;
            line_q <= 1'b0; trig_q <= 1'b0; pkt_q <= 1'b0; msg_q <= 1'b0;
        end else begin
            trig_q <= 1'b0;
            pkt_q  <= 1'b0;
            msg_q  <= 1'b0;
            if (accept) begin
                left   <= pkt_count_i;
                tidx   <= '0;
                cnt    <= full_len;
                line_q <= sot_rev[0];
                trig_q <= 1'b1;
            end else if (st != ST_IDLE) begin
                if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end else if (fetch) begin
                    line_q   <= h0;
                    h1_q     <= h1;
                    off_q    <= off;
                    cnt      <= first_len;
                    half_q   <= 1'b0;
                    pidx     <= fetch_idx;
                    mil_lvl  <= h1;
                    mil_prev <= data_bit;
                end else begin
                    unique case (st)
                        ST_SOT: begin
                            tidx   <= tidx + 1'b1;
                            line_q <= sot_rev[tidx + 1'b1];
                            cnt    <= full_len;
                        end
                        ST_PAY: begin
                            if (!half_q) begin
                                line_q <= h1_q;
                                half_q <= 1'b1;
                                cnt    <= second_len;
                            end else begin
                                tidx   <= '0;
                                line_q <= eot_rev[0];
                                cnt    <= full_len;
                            end
                        end
                        ST_EOT: begin
                            if (!tag_last) begin
                                tidx   <= tidx + 1'b1;
                                line_q <= eot_rev[tidx + 1'b1];
                                cnt    <= full_len;
                            end else begin
                                pkt_q <= 1'b1;
                                if (left == NPW'(1)) begin
                                    line_q <= 1'b0;
                                    msg_q  <= 1'b1;
                                end else begin
                                    left   <= left - 1'b1;
                                    tidx   <= '0;
                                    line_q <= sot_rev[0];
                                    cnt    <= full_len;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign line_o     = line_q;
    assign trig_o     = trig_q;
    assign busy_o     = (st != ST_IDLE);
    assign pkt_done_o = pkt_q;
    assign msg_done_o = msg_q;

    // R9
    idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !line_o);
    // R1
    trig_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> busy_o);
    // R1
    no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !trig_o);
    // R8
    msg_with_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_done_o |-> (pkt_done_o && !busy_o));
    // R6
    skew_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_PAY) && (half_len_i != '0)) |-> ((off_q < hl_s) && (off_q > -hl_s)));
endmodule

// File: tb/pkt_stim_gen_test.sv
`timescale 1ns/1ps
module pkt_stim_gen_test;
    localparam int TAGB = 8;
    localparam int PAYB = 8;
    localparam int MAXS = 8192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, miller_i = 1'b0, prbs_i = 1'b0, jitter_en_i = 1'b0;
    logic [8:0] seed_i = 9'h1;
    logic [PAYB-1:0] pattern_i = '0;
    logic [TAGB-1:0] sot_tag_i = '0, eot_tag_i = '0;
    logic [7:0] pkt_count_i = '0, half_len_i = 8'd1, bias_i = '0;
    logic line_o, trig_o, busy_o, pkt_done_o, msg_done_o;

    int errors = 0;
    int checks = 0;

    bit exp_line [MAXS];
    bit is_tag [MAXS];
    int pend [8];
    int exp_len;

    always #10 clk = ~clk;

    pkt_stim_gen uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .miller_i(miller_i),
        .prbs_i(prbs_i), .seed_i(seed_i), .pattern_i(pattern_i),
        .sot_tag_i(sot_tag_i), .eot_tag_i(eot_tag_i), .pkt_count_i(pkt_count_i),
        .half_len_i(half_len_i), .bias_i(bias_i), .jitter_en_i(jitter_en_i),
        .line_o(line_o), .trig_o(trig_o), .busy_o(busy_o),
        .pkt_done_o(pkt_done_o), .msg_done_o(msg_done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic add_seg(input bit v, input int n, input bit tg);
        for (int i = 0; i < n; i++) begin
            exp_line[exp_len] = v;
            is_tag[exp_len] = tg;
            exp_len++;
        end
    endtask

    // Expected stream built from R2..R6 with no jitter
    task automatic build(input bit mil, input bit src, input int h, input int bias,
                         input int np, input logic [8:0] seed, input logic [7:0] pat,
                         input logic [7:0] st, input logic [7:0] et);
        logic [8:0] s;
        int d;
        bit b, lvl, prev, a0, a1;
        exp_len = 0;
        s = (seed == 0) ? 9'h1 : seed;
        d = bias;
        if (d > h - 1) d = h - 1;
        if (d < -(h - 1)) d = -(h - 1);
        for (int p = 0; p < np; p++) begin
            for (int i = TAGB - 1; i >= 0; i--) add_seg(st[i], 2 * h, 1'b1);
            lvl = st[0];
            prev = 1'b1;
            for (int i = 0; i < PAYB; i++) begin
                if (src) begin
                    b = s[8];
                    s = {s[7:0], s[8] ^ s[4]};
                end else begin
                    b = pat[PAYB - 1 - i];
                end
                if (!mil) begin a0 = b; a1 = !b; end
                else if (b) begin a0 = lvl; a1 = !lvl; end
                else if (!prev) begin a0 = !lvl; a1 = !lvl; end
                else begin a0 = lvl; a1 = lvl; end
                lvl = a1;
                prev = b;
                add_seg(a0, h + d, 1'b0);
                add_seg(a1, h - d, 1'b0);
            end
            for (int i = TAGB - 1; i >= 0; i--) add_seg(et[i], 2 * h, 1'b1);
            pend[p] = exp_len;
        end
    endtask

    task automatic run(input bit mil, input bit src, input int h, input int bias,
                       input int np, input bit jit, input logic [8:0] seed,
                       input logic [7:0] pat, input logic [7:0] st, input logic [7:0] et);
        int bad_line, bad_trig, bad_pkt, bad_busy, payload_diff, first_k;
        int act_first, exp_first, pk;
        build(mil, src, h, bias, np, seed, pat, st, et);
        miller_i = mil; prbs_i = src; half_len_i = 8'(h); bias_i = 8'(bias);
        pkt_count_i = 8'(np); jitter_en_i = jit; seed_i = seed;
        pattern_i = pat; sot_tag_i = st; eot_tag_i = et;
        bad_line = 0; bad_trig = 0; bad_pkt = 0; bad_busy = 0; payload_diff = 0;
        first_k = -1; act_first = 0; exp_first = 0; pk = 0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        for (int k = 0; k <= exp_len; k++) begin
            if (k == 3) start_i = 1'b1;
            if (k == 4) start_i = 1'b0;
            if (k < exp_len) begin
                if (!busy_o || msg_done_o) bad_busy++;
                if (line_o !== exp_line[k]) begin
                    if (jit && !is_tag[k]) payload_diff++;
                    else begin
                        bad_line++;
                        if (first_k < 0) begin
                            first_k = k; act_first = line_o; exp_first = exp_line[k];
                        end
                    end
                end
            end else begin
                if (busy_o || !msg_done_o || line_o) bad_busy++;
            end
            if (trig_o !== (k == 0)) bad_trig++;
            if (pk < np && k == pend[pk]) begin
                if (!pkt_done_o) bad_pkt++;
                pk++;
            end else if (pkt_done_o) bad_pkt++;
            @(negedge clk);
        end
        check(bad_line == 0, jit ? "R7 tag samples under jitter" :
              (mil ? "R4/R2/R5/R6 Miller stream" : "R3/R2/R5/R6 Manchester stream"),
              act_first, exp_first);
        if (bad_line != 0) $display("  at sample %0d h=%0d bias=%0d np=%0d", first_k, h, bias, np);
        check(bad_trig == 0, "R1 single trigger, restart ignored", bad_trig, 0);
        check(bad_pkt == 0, "R8 pkt_done positions", bad_pkt, 0);
        check(bad_busy == 0, "R8 busy/msg_done/line at end", bad_busy, 0);
        if (jit) check(payload_diff > 0, "R7 jitter moves payload edges", payload_diff, 1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        int biases [4];
        int hs [3];
        biases = '{-3, 0, 2, 9};
        hs = '{1, 3, 5};
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!line_o && !busy_o && !trig_o && !pkt_done_o && !msg_done_o,
              "R9 reset outputs low", {line_o, busy_o, trig_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: zero packet count ignored
        pkt_count_i = 8'd0;
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy_o && !trig_o && !line_o, "R1 zero count ignored", busy_o, 0);
        // Sweep
        for (int m = 0; m < 2; m++)
            for (int sr = 0; sr < 2; sr++)
                for (int hi = 0; hi < 3; hi++)
                    for (int bi = 0; bi < 4; bi++)
                        for (int np = 1; np <= 3; np++)
                            run(m[0], sr[0], hs[hi], biases[bi], np, 1'b0,
                                9'(37 * (hi + 1) + bi), 8'(8'hA5 ^ (np * 17 + bi)),
                                8'(8'hE2 ^ bi), 8'(8'h1D ^ (hi << 1)));
        // R5 zero seed behaves as seed 1
        run(1'b0, 1'b1, 2, 0, 2, 1'b0, 9'h000, 8'h00, 8'hC3, 8'h3C);
        // R7 jitter scenarios
        run(1'b0, 1'b1, 5, 0, 2, 1'b1, 9'h0B7, 8'h00, 8'hF0, 8'h0F);
        run(1'b1, 1'b0, 5, 1, 3, 1'b1, 9'h155, 8'h6C, 8'h81, 8'h7E);
        // R9 idle after sweeps
        repeat (4) @(negedge clk);
        check(!line_o && !busy_o, "R9 idle line low", line_o, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule